// File: doc/BRIEF.md
# Event Channel Group Controller

This block owns the on/off state of 32 event-routing channels. Each channel has one enable bit, and the 32 bits drive the `chan_en` output vector. Software can turn channels on or off one at a time through a write-one-to-set register and a write-one-to-clear register. It can also switch many channels at once by firing the enable or disable task of one of six channel groups. Each group has a 32-bit membership mask.

A group task fires in one of two ways. Software can write 1 to the task's register. A channel pulse can also fire it, through a subscribe register tied to that task. The subscribe register names a channel and carries an enable flag. A pulse on that channel fires the task only if the channel is enabled at that moment.

All register access goes through a single-cycle bus. Writes take effect at the clock edge, and reads return data in the same cycle as the address.

Top module: `chgrp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all channel enable bits, all six group masks and all twelve subscribe registers read zero.
- R2: A write to the set register (0x504) sets every enable bit that is 1 in the write data and leaves the other bits unchanged. `chan_en` shows the result after the next clock edge.
- R3: A write to the clear register (0x508) clears every enable bit that is 1 in the write data. Writing 0xFFFFFFFF disables every channel.
- R4: The mask of group n sits at 0x800 + 4n. It is a plain read/write register and reads back the last value written.
- R5: Task address 8n is group n's enable task. Writing data with bit 0 set ORs group n's mask into the enable bits.
- R6: Task address 8n+4 is group n's disable task. Writing data with bit 0 set clears the enable bit of every channel in group n's mask.
- R7: A task write whose bit 0 is 0 changes nothing.
- R8: Each task's subscribe register sits 0x80 above the task address. Bits [4:0] hold a channel number and bit 31 holds the enable flag. All other bits read 0, and writing 0 removes the subscription.
- R9: When a subscribe register's flag is set, a pulse on its channel input fires the task, provided that channel's enable bit is 1.
- R10: A pulse has no effect on a disabled channel, on a channel no task subscribes to, or through a subscribe register whose flag is 0. With no bus write, `chan_en` then holds its value.
- R11: When several updates reach the same bit in one cycle, clear writes and disable tasks win over set writes and enable tasks.
- R12: A read of the status register (0x500) returns the current channel enable bits. A read of a task, set or clear address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| chan_pulse | input | 32 | One event pulse input per channel |
| chan_en | output | 32 | Channel enable vector |

## Verification
The hardest case to reach is a single cycle with conflicting updates. One example is a bus set write landing together with a channel pulse that fires a subscribed disable task. Another is one pulse firing the enable and disable tasks of the same group at once. Directed steps build exactly these cases: they first program a group mask and two subscriptions on an enabled channel, then issue the write and the pulse in the same cycle. The constrained random phase keeps several subscriptions live with wide pulse vectors, so that such collisions also occur often without being set up on purpose.

// File: rtl/chgrp_pkg.sv
`timescale 1ns/1ps
// Shared sizes and the register map of the channel group controller.
// Assumes 32 channels (one data word) and 4-byte aligned registers.
package chgrp_pkg;
    parameter int NUM_CH    = 32;
    parameter int NUM_GRP   = 6;
    parameter int ADDR_W    = 12;
    localparam int DATA_W   = NUM_CH;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int NUM_TASK = 2 * NUM_GRP;
    localparam int SUB_FLAG = DATA_W - 1;

    localparam int TASK_BASE = 'h000;
    localparam int SUB_OFS   = 'h080;
    localparam int STAT_ADDR = 'h500;
    localparam int SET_ADDR  = 'h504;
    localparam int CLR_ADDR  = 'h508;
    localparam int MASK_BASE = 'h800;
endpackage

// File: rtl/chgrp_decode.sv
`timescale 1ns/1ps
// Write decoder: turns one bus write into per-register strobes.
// Assumes word-aligned addresses; task index t lives at TASK_BASE + 4*t.
module chgrp_decode
    import chgrp_pkg::*;
(
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                task_bit,
    output logic [NUM_TASK-1:0] sw_fire,
    output logic [NUM_TASK-1:0] sub_wr,
    output logic [NUM_GRP-1:0]  mask_wr,
    output logic                set_wr,
    output logic                clr_wr
);
    logic wr;
    assign wr     = bus_sel & bus_we;
    assign set_wr = wr && (bus_addr == ADDR_W'(SET_ADDR));
    assign clr_wr = wr && (bus_addr == ADDR_W'(CLR_ADDR));

    // Per task: software firing and subscribe register write strobes.
    for (genvar t = 0; t < NUM_TASK; t++) begin : g_task
        assign sw_fire[t] = wr && task_bit && (bus_addr == ADDR_W'(TASK_BASE + 4 * t));
        assign sub_wr[t]  = wr && (bus_addr == ADDR_W'(TASK_BASE + SUB_OFS + 4 * t));
    end

    // Per group: membership mask write strobes.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
        assign mask_wr[g] = wr && (bus_addr == ADDR_W'(MASK_BASE + 4 * g));
    end
endmodule

// File: rtl/chgrp_subscribe.sv
`timescale 1ns/1ps
// Subscribe registers, one per task, and the pulse-to-task firing logic.
// A task fires in the same cycle as a pulse on its channel, gated by the
// channel's current enable bit and the subscription flag.
module chgrp_subscribe
    import chgrp_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_TASK-1:0]              sub_wr,
    input  logic [CH_W-1:0]                  wr_ch,
    input  logic                             wr_flag,
    input  logic [NUM_CH-1:0]                chan_pulse,
    input  logic [NUM_CH-1:0]                chan_en,
    output logic [NUM_TASK-1:0]              hw_fire,
    output logic [NUM_TASK-1:0][DATA_W-1:0]  sub_rd
);
    for (genvar t = 0; t < NUM_TASK; t++) begin : g_sub
        logic [CH_W-1:0] ch_q;
        logic            flag_q;

        // Hold the subscribed channel number and its enable flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_q   <= '0;
                flag_q <= 1'b0;
            end else if (sub_wr[t]) begin
                ch_q   <= wr_ch;
                flag_q <= wr_flag;
            end
        end

        assign hw_fire[t] = flag_q & chan_pulse[ch_q] & chan_en[ch_q];
        assign sub_rd[t]  = {flag_q, {(DATA_W - 1 - CH_W){1'b0}}, ch_q};
    end
endmodule

// File: rtl/chgrp_masks.sv
`timescale 1ns/1ps
// Group membership masks: plain read/write registers, one per group.
module chgrp_masks
    import chgrp_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GRP-1:0]              mask_wr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_GRP-1:0][NUM_CH-1:0]  masks
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        // Load the group's membership mask on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)          masks[g] <= '0;
            else if (mask_wr[g]) masks[g] <= wdata;
        end
    end
endmodule

// File: rtl/chgrp_enables.sv
`timescale 1ns/1ps
// Channel enable register. Within one cycle, all set sources are merged
// first and all clear sources are applied after them, so a clear wins.
// Even task indices enable a group and odd ones disable it.
module chgrp_enables
    import chgrp_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_wr,
    input  logic                            clr_wr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_TASK-1:0]             fire,
    input  logic [NUM_GRP-1:0][NUM_CH-1:0]  masks,
    output logic [NUM_CH-1:0]               en_q
);
    logic [NUM_CH-1:0] set_vec;
    logic [NUM_CH-1:0] clr_vec;

    // Gather set and clear bits from bus writes and fired group tasks.
    always_comb begin
        set_vec = set_wr ? wdata : '0;
        clr_vec = clr_wr ? wdata : '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (fire[2 * g])     set_vec = set_vec | masks[g];
            if (fire[2 * g + 1]) clr_vec = clr_vec | masks[g];
        end
    end

    // Apply the sets first, then the clears.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_vec) & ~clr_vec;
    end
endmodule

// File: rtl/chgrp_ctrl.sv
`timescale 1ns/1ps
// Event channel group controller top level. It owns the 32 channel
// enable bits, six group masks and twelve subscribed tasks. The bus is
// single-cycle: writes act at the clock edge and reads are combinational.
module chgrp_ctrl
    import chgrp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0]  chan_pulse,
    output logic [NUM_CH-1:0]  chan_en
);
    logic [NUM_TASK-1:0]             sw_fire, hw_fire, sub_wr;
    logic [NUM_GRP-1:0]              mask_wr;
    logic                            set_wr, clr_wr;
    logic [NUM_GRP-1:0][NUM_CH-1:0]  masks;
    logic [NUM_TASK-1:0][DATA_W-1:0] sub_rd;
    logic [NUM_CH-1:0]               en_q;

    chgrp_decode u_decode (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .task_bit(bus_wdata[0]),
        .sw_fire (sw_fire),
        .sub_wr  (sub_wr),
        .mask_wr (mask_wr),
        .set_wr  (set_wr),
        .clr_wr  (clr_wr)
    );

    chgrp_subscribe u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_wr    (sub_wr),
        .wr_ch     (bus_wdata[CH_W-1:0]),
        .wr_flag   (bus_wdata[SUB_FLAG]),
        .chan_pulse(chan_pulse),
        .chan_en   (en_q),
        .hw_fire   (hw_fire),
        .sub_rd    (sub_rd)
    );

    chgrp_masks u_masks (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_wr(mask_wr),
        .wdata  (bus_wdata),
        .masks  (masks)
    );

    chgrp_enables u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_wr(set_wr),
        .clr_wr(clr_wr),
        .wdata (bus_wdata),
        .fire  (sw_fire | hw_fire),
        .masks (masks),
        .en_q  (en_q)
    );

    assign chan_en = en_q;

    // Read mux: status, subscribe and mask registers; all else reads 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata = en_q;
        for (int t = 0; t < NUM_TASK; t++)
            if (bus_addr == ADDR_W'(TASK_BASE + SUB_OFS + 4 * t)) bus_rdata = sub_rd[t];
        for (int g = 0; g < NUM_GRP; g++)
            if (bus_addr == ADDR_W'(MASK_BASE + 4 * g)) bus_rdata = masks[g];
    end
endmodule

// File: rtl/chgrp_ctrl_checker.sv
`timescale 1ns/1ps
// Port-level properties of the channel group controller, bound to the top.
module chgrp_ctrl_checker
    import chgrp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0]  chan_pulse,
    input logic [NUM_CH-1:0]  chan_en
);
    logic wr;
    assign wr = bus_sel & bus_we;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> chan_en == '0); // R1

    AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(SET_ADDR) && chan_pulse == '0)
        |=> ((chan_en & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(CLR_ADDR))
        |=> ((chan_en & $past(bus_wdata)) == '0)); // R11

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && chan_pulse == '0) |=> $stable(chan_en)); // R10

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == ADDR_W'(STAT_ADDR))
        |-> bus_rdata == chan_en); // R12
endmodule

bind chgrp_ctrl chgrp_ctrl_checker u_chk (.*);

// File: tb/chgrp_ctrl_test.sv
`timescale 1ns/1ps
module chgrp_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, chan_pulse = '0, chan_en;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] m_en;
    logic [31:0] m_mask [6];
    logic [4:0]  m_sch  [12];
    logic        m_sfl  [12];

    chgrp_ctrl uut (.*);

    always #2 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Expected enable vector after one cycle with the given bus write and pulses.
    function automatic logic [31:0] next_en(logic wr, logic [11:0] a, logic [31:0] d,
                                            logic [31:0] p);
        logic [31:0] s = '0, c = '0;
        logic [11:0] fired = '0;
        if (wr) begin
            if (a == 12'h504) s = d;
            if (a == 12'h508) c = d;
            if (a < 12'h030 && a[1:0] == 2'b00 && d[0]) fired[a[5:2]] = 1'b1;
        end
        for (int t = 0; t < 12; t++)
            if (m_sfl[t] && p[m_sch[t]] && m_en[m_sch[t]]) fired[t] = 1'b1;
        for (int t = 0; t < 12; t++)
            if (fired[t]) begin
                if (t % 2 == 0) s = s | m_mask[t/2];
                else            c = c | m_mask[t/2];
            end
        return (m_en | s) & ~c;
    endfunction

    // One bus cycle (write or idle) with pulses; checks chan_en after the edge.
    task automatic cyc(string req, logic wr, logic [11:0] a, logic [31:0] d, logic [31:0] p);
        logic [31:0] exp;
        @(negedge clk);
        bus_sel = wr; bus_we = wr; bus_addr = a; bus_wdata = d; chan_pulse = p;
        exp = next_en(wr, a, d, p);
        @(posedge clk); #1;
        m_en = exp;
        if (wr && a >= 12'h800 && a < 12'h818) m_mask[(a - 12'h800) >> 2] = d;
        if (wr && a >= 12'h080 && a < 12'h0B0) begin
            m_sch[(a - 12'h080) >> 2] = d[4:0];
            m_sfl[(a - 12'h080) >> 2] = d[31];
        end
        chk(req, chan_en, m_en);
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0; chan_pulse = '0;
        #1 chk(req, bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed = $urandom(32'd20240611);
        m_en = '0;
        for (int i = 0; i < 6; i++) m_mask[i] = '0;
        for (int i = 0; i < 12; i++) begin m_sch[i] = '0; m_sfl[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1", chan_en, 32'h0);
        rd("R1", 12'h800, 32'h0);
        rd("R1", 12'h0AC, 32'h0);

        // R2 / R12: set and status read
        cyc("R2", 1, 12'h504, 32'h0000_00F5, '0);
        rd("R12", 12'h500, 32'h0000_00F5);
        rd("R12", 12'h504, 32'h0);
        // R3: clear
        cyc("R3", 1, 12'h508, 32'h0000_0005, '0);
        // R4: masks
        cyc("R4", 1, 12'h800, 32'hFFFF_0000, '0);
        cyc("R4", 1, 12'h814, 32'h0000_0F0F, '0);
        rd("R4", 12'h800, 32'hFFFF_0000);
        rd("R4", 12'h814, 32'h0000_0F0F);
        // R5 / R6 / R7: group tasks
        cyc("R5", 1, 12'h000, 32'h1, '0);
        cyc("R7", 1, 12'h02C, 32'h2, '0);
        cyc("R6", 1, 12'h02C, 32'h1, '0);
        cyc("R6", 1, 12'h004, 32'h1, '0);
        // R8: subscribe readback
        cyc("R8", 1, 12'h088, 32'hFFFF_FFE3, '0);
        rd("R8", 12'h088, 32'h8000_0003);
        // R9: channel 3 disabled -> pulse ignored (R10), then enabled -> fires
        cyc("R4", 1, 12'h804, 32'h00F0_0000, '0);
        cyc("R10", 0, 12'h000, 32'h0, 32'h0000_0008);
        cyc("R2", 1, 12'h504, 32'h0000_0008, '0);
        cyc("R9", 0, 12'h000, 32'h0, 32'h0000_0008);
        // R10: flag cleared -> pulse ignored
        cyc("R3", 1, 12'h508, 32'hFFFF_FFFF, '0);
        cyc("R2", 1, 12'h504, 32'h0000_0008, '0);
        cyc("R8", 1, 12'h088, 32'h0000_0003, '0);
        cyc("R10", 0, 12'h000, 32'h0, 32'hFFFF_FFFF);
        // R11: set write together with pulse-fired disable on same bits
        cyc("R11", 1, 12'h08C, 32'h8000_0003, '0);
        cyc("R11", 1, 12'h504, 32'h00F0_0000, 32'h0000_0008);
        // R11: enable and disable of group 1 fired by one pulse
        cyc("R11", 1, 12'h088, 32'h8000_0003, '0);
        cyc("R11", 0, 12'h000, 32'h0, 32'h0000_0008);
        rd("R12", 12'h500, m_en);

        // Constrained random mix of all operations (R2, R3, R5, R6, R9, R11)
        for (int i = 0; i < 600; i++) begin
            int unsigned op = $urandom % 6;
            int unsigned t  = $urandom % 12;
            logic [31:0] p  = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
            case (op)
                0: cyc("R2", 1, 12'h504, $urandom & $urandom, p);
                1: cyc("R3", 1, 12'h508, $urandom & $urandom & $urandom, p);
                2: cyc("R5", 1, 12'(4 * t), $urandom, p);
                3: cyc("R4", 1, 12'(12'h800 + 4 * (t % 6)), $urandom, p);
                4: cyc("R9", 1, 12'(12'h080 + 4 * t), $urandom, p);
                default: cyc("R11", 0, 12'h000, 32'h0, p);
            endcase
            if (i % 50 == 0) rd("R12", 12'h500, m_en);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule